// File: doc/BRIEF.md
# Daisy-Chain Interrupt Acknowledge Unit

This unit runs the interrupt side of a peripheral that sits in a priority daisy chain. Each source raises a level request. The unit copies the requests into pending bits on a half-rate clock enable. The refresh stalls while the external register pointer selects status registers 2 or 3. The unit raises an active-low interrupt request whenever a pending source is not masked by an in-service source of equal or higher priority.

An acknowledge cycle starts when the active-low acknowledge input is sampled low on a rising clock edge. At the first falling edge of the read strobe inside that cycle, the unit claims the cycle if the chain enable input is high and an eligible source exists. It then sets that source's in-service latch and drives an 8-bit vector onto the data bus while the strobe stays low. The enable output passes the chain enable downstream only when this unit has nothing pending and nothing in service. A control write outside acknowledge cycles signals end of interrupt and retires the highest-priority in-service source.

All strobes are sampled on `clk_i`, and edges are detected against the previous sample.

Top module: `irq_daisy_ack`

## Requirements
- R1: After reset, no source is pending or in service: `int_no` is 1, `data_oe_o` is 0, `data_o` is 0 and `ieo_o` follows `iei_i`.
- R2: `ack_ni` acts only through its value sampled on the rising clock edge. A read falling edge taken while the sampled value is high does not start an acknowledge and drives nothing onto the data bus.
- R3: While the sampled acknowledge is low, `wr_ni`, `dc_i` and `ch_i` have no effect. In particular, a write edge in that time does not clear an in-service bit.
- R4: A read falling edge seen at a clock edge while the sampled acknowledge is low, `iei_i` is high and an eligible source exists sets the in-service bit of the selected source at that edge. From then until the sampled acknowledge goes high, `data_oe_o` is 1 whenever `rd_ni` is low.
- R5: The vector is `VEC_BASE` with bits 3:1 replaced by the 3-bit index of the selected source. While `data_oe_o` is 0, `data_o` reads 0.
- R6: Source 0 has the highest priority and priority falls as the index rises. A pending source is eligible only if no source of equal or higher priority is in service, and the eligible source with the lowest index is selected.
- R7: `int_no` is 0 exactly when an eligible source exists. It therefore returns to 1 on the same edge that claims the acknowledge, unless a higher-priority request appears.
- R8: Only the first read falling edge of an acknowledge cycle is acted on. Further reads before the sampled acknowledge returns high set no in-service bit.
- R9: Pending bits take the value of `src_req_i` only on cycles where the half-rate enable is active. The enable is active on every second unfrozen cycle.
- R10: While `ptr_i` equals 2 or 3, the half-rate enable is off and its phase holds, so pending bits stay unchanged.
- R11: `ieo_o` is 1 only when `iei_i` is 1, no pending bit is set and no in-service bit is set.
- R12: A write falling edge with the sampled acknowledge high, `dc_i` 0 and `ch_i` 1 clears the lowest-index in-service bit that is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ack_ni | input | 1 | Interrupt acknowledge, active low |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| dc_i | input | 1 | Data (1) or control (0) access select |
| ch_i | input | 1 | Channel select; 1 with a control write means end of interrupt |
| iei_i | input | 1 | Daisy-chain enable in |
| ptr_i | input | PTR_W | Current register pointer |
| src_req_i | input | NSRC | Level requests from the sources |
| int_no | output | 1 | Interrupt request, active low |
| ieo_o | output | 1 | Daisy-chain enable out |
| data_o | output | 8 | Vector bus |
| data_oe_o | output | 1 | Bus drive enable |

## Verification
The assertions assume that strobes, selects and `ptr_i` are already synchronous to `clk_i` and change only between edges. They also assume that the upstream chain holds `iei_i` steady around the read edge. The stimulus drives every input 1 ns after a rising edge. It opens and closes acknowledge windows and read and write pulses at random but keeps each one at least a cycle wide, so every edge is seen. It keeps `ptr_i` in 0 to 7 and weights it toward the frozen values, so that long stalls do occur.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;
  localparam int unsigned VEC_IDX_W = 3;

  typedef struct packed {
    logic rd_fall;
    logic wr_fall;
  } strobe_ev_t;

  function automatic logic [7:0] make_vector(input logic [7:0] base,
                                             input logic [VEC_IDX_W-1:0] idx);
    return {base[7:4], idx, base[0]};
  endfunction
endpackage

// File: rtl/irq_half_rate.sv
module irq_half_rate #(
  parameter int unsigned PTR_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PTR_W-1:0] ptr_i,
  output logic             tick_o
);
  logic phase_q;
  logic frozen;

  assign frozen = (ptr_i == PTR_W'(2)) || (ptr_i == PTR_W'(3));
  assign tick_o = phase_q & ~frozen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     phase_q <= 1'b0;
    else if (!frozen) phase_q <= ~phase_q;
  end
endmodule

// File: rtl/irq_pending.sv
module irq_pending #(
  parameter int unsigned NSRC = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic [NSRC-1:0] src_req_i,
  output logic [NSRC-1:0] ip_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ip_o <= '0;
    else if (tick_i) ip_o <= src_req_i;
  end
endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
  parameter int unsigned NSRC  = 6,
  parameter int unsigned IDX_W = 3
) (
  input  logic [NSRC-1:0]  ip_i,
  input  logic [NSRC-1:0]  ius_i,
  output logic             any_elig_o,
  output logic [IDX_W-1:0] sel_idx_o,
  output logic [NSRC-1:0]  sel_oh_o,
  output logic [NSRC-1:0]  eoi_mask_o
);
  logic [NSRC-1:0] elig;

  for (genvar g = 0; g < NSRC; g++) begin : g_elig
    assign elig[g] = ip_i[g] & ~(|ius_i[g:0]);
  end

  assign any_elig_o = |elig;

  always_comb begin
    sel_idx_o = '0;
    sel_oh_o  = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (elig[i]) begin
        sel_idx_o = IDX_W'(i);
        sel_oh_o  = NSRC'(1) << i;
      end
    end
  end

  always_comb begin
    eoi_mask_o = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (ius_i[i]) eoi_mask_o = NSRC'(1) << i;
    end
  end
endmodule

// File: rtl/irq_ack_ctrl.sv
module irq_ack_ctrl
  import irq_ack_pkg::*;
#(
  parameter int unsigned NSRC     = 6,
  parameter logic [7:0]  VEC_BASE = 8'h61
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ack_ni,
  input  logic                 rd_ni,
  input  logic                 wr_ni,
  input  logic                 dc_i,
  input  logic                 ch_i,
  input  logic                 iei_i,
  input  logic                 any_elig_i,
  input  logic [VEC_IDX_W-1:0] sel_idx_i,
  input  logic [NSRC-1:0]      sel_oh_i,
  input  logic [NSRC-1:0]      eoi_mask_i,
  output logic [NSRC-1:0]      ius_o,
  output logic                 ack_q_o,
  output logic [7:0]           data_o,
  output logic                 data_oe_o
);
  logic       rd_q, wr_q, done_q, served_q;
  logic [7:0] vec_q;
  strobe_ev_t ev;
  logic       ack_rd, hit, eoi;

  assign ev.rd_fall = rd_q & ~rd_ni;
  assign ev.wr_fall = wr_q & ~wr_ni;
  assign ack_rd     = ev.rd_fall & ~ack_q_o & ~done_q;
  assign hit        = ack_rd & iei_i & any_elig_i;
  // write-side selects only count outside an acknowledge cycle
  assign eoi        = ev.wr_fall & ack_q_o & ~dc_i & ch_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q_o  <= 1'b1;
      rd_q     <= 1'b1;
      wr_q     <= 1'b1;
      done_q   <= 1'b0;
      served_q <= 1'b0;
      vec_q    <= '0;
      ius_o    <= '0;
    end else begin
      ack_q_o <= ack_ni;
      rd_q    <= rd_ni;
      wr_q    <= wr_ni;
      if (ack_q_o) begin
        done_q   <= 1'b0;
        served_q <= 1'b0;
      end else begin
        done_q <= done_q | ev.rd_fall;
        if (hit) served_q <= 1'b1;
      end
      if (hit) begin
        vec_q <= make_vector(VEC_BASE, sel_idx_i);
        ius_o <= ius_o | sel_oh_i;
      end else if (eoi) begin
        ius_o <= ius_o & ~eoi_mask_i;
      end
    end
  end

  assign data_oe_o = served_q & ~ack_q_o & ~rd_ni;
  assign data_o    = data_oe_o ? vec_q : 8'h00;
endmodule

// File: rtl/irq_daisy_ack.sv
module irq_daisy_ack
  import irq_ack_pkg::*;
#(
  parameter int unsigned NSRC     = 6,
  parameter int unsigned PTR_W    = 4,
  parameter logic [7:0]  VEC_BASE = 8'h61
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ack_ni,
  input  logic             rd_ni,
  input  logic             wr_ni,
  input  logic             dc_i,
  input  logic             ch_i,
  input  logic             iei_i,
  input  logic [PTR_W-1:0] ptr_i,
  input  logic [NSRC-1:0]  src_req_i,
  output logic             int_no,
  output logic             ieo_o,
  output logic [7:0]       data_o,
  output logic             data_oe_o
);
  localparam int unsigned MAX_SRC = 1 << VEC_IDX_W;

  if (NSRC < 1 || NSRC > MAX_SRC) begin : g_bad_nsrc
    $error("NSRC out of range");
  end

  logic                 tick;
  logic [NSRC-1:0]      ip, ius, sel_oh, eoi_mask;
  logic                 any_elig, ack_q;
  logic [VEC_IDX_W-1:0] sel_idx;

  irq_half_rate #(.PTR_W(PTR_W)) i_half_rate (
    .clk_i (clk_i), .rst_ni(rst_ni), .ptr_i(ptr_i), .tick_o(tick)
  );

  irq_pending #(.NSRC(NSRC)) i_pending (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .src_req_i(src_req_i), .ip_o(ip)
  );

  irq_prio #(.NSRC(NSRC), .IDX_W(VEC_IDX_W)) i_prio (
    .ip_i      (ip),
    .ius_i     (ius),
    .any_elig_o(any_elig),
    .sel_idx_o (sel_idx),
    .sel_oh_o  (sel_oh),
    .eoi_mask_o(eoi_mask)
  );

  irq_ack_ctrl #(.NSRC(NSRC), .VEC_BASE(VEC_BASE)) i_ack_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ack_ni    (ack_ni),
    .rd_ni     (rd_ni),
    .wr_ni     (wr_ni),
    .dc_i      (dc_i),
    .ch_i      (ch_i),
    .iei_i     (iei_i),
    .any_elig_i(any_elig),
    .sel_idx_i (sel_idx),
    .sel_oh_i  (sel_oh),
    .eoi_mask_i(eoi_mask),
    .ius_o     (ius),
    .ack_q_o   (ack_q),
    .data_o    (data_o),
    .data_oe_o (data_oe_o)
  );

  assign int_no = ~any_elig;
  assign ieo_o  = iei_i & ~(|ius) & ~(|ip);
endmodule

// File: rtl/irq_daisy_ack_chk.sv
module irq_daisy_ack_chk #(
  parameter int unsigned NSRC  = 6,
  parameter int unsigned PTR_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [PTR_W-1:0] ptr_i,
  input logic [NSRC-1:0]  ip,
  input logic [NSRC-1:0]  ius,
  input logic             ack_q,
  input logic             iei_i,
  input logic             ieo_o,
  input logic             int_no,
  input logic             data_oe_o
);
  logic frozen;
  assign frozen = (ptr_i == PTR_W'(2)) || (ptr_i == PTR_W'(3));

  // R10
  freeze_holds_ip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(frozen) |-> $stable(ip));

  // R9
  half_rate_ip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ip) |=> $stable(ip));

  // R4
  ius_set_in_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(ius & ~$past(ius))) |-> (!$past(ack_q) && $countones(ius & ~$past(ius)) == 1));

  // R12
  ius_clr_outside_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|($past(ius) & ~ius)) |-> ($past(ack_q) && $countones($past(ius) & ~ius) == 1));

  // R7
  int_drop_on_claim_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|(ius & ~$past(ius))) && $stable(ip)) |-> int_no);

  // R11
  ieo_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ieo_o |-> (iei_i && int_no));

  // R4
  bus_only_in_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> !ack_q);
endmodule

bind irq_daisy_ack irq_daisy_ack_chk #(.NSRC(NSRC), .PTR_W(PTR_W)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ptr_i    (ptr_i),
  .ip       (ip),
  .ius      (ius),
  .ack_q    (ack_q),
  .iei_i    (iei_i),
  .ieo_o    (ieo_o),
  .int_no   (int_no),
  .data_oe_o(data_oe_o)
);

// File: tb/test_irq_daisy_ack.sv
`timescale 1ns/1ps
module test_irq_daisy_ack;
  localparam int unsigned NSRC  = 6;
  localparam int unsigned PTR_W = 4;
  localparam logic [7:0]  BASE  = 8'h61;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ack_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, dc = 1'b1, ch = 1'b0, iei = 1'b1;
  logic [PTR_W-1:0] ptr = '0;
  logic [NSRC-1:0]  src = '0;
  logic int_n, ieo, oe;
  logic [7:0] data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  irq_daisy_ack #(.NSRC(NSRC), .PTR_W(PTR_W), .VEC_BASE(BASE)) i_irq_daisy_ack (
    .clk_i(clk), .rst_ni(rst_n), .ack_ni(ack_n), .rd_ni(rd_n), .wr_ni(wr_n),
    .dc_i(dc), .ch_i(ch), .iei_i(iei), .ptr_i(ptr), .src_req_i(src),
    .int_no(int_n), .ieo_o(ieo), .data_o(data), .data_oe_o(oe)
  );

  // reference state, built from the requirements
  logic            m_phase, m_ack, m_rd, m_wr, m_done, m_served;
  logic [NSRC-1:0] m_ip, m_ius;
  logic [7:0]      m_vec;

  function automatic logic [7:0] vec_of(input int idx);
    logic [2:0] f;
    f = 3'(idx);
    return {BASE[7:4], f, BASE[0]};
  endfunction

  function automatic int pick(input logic [NSRC-1:0] ip, input logic [NSRC-1:0] ius);
    for (int i = 0; i < NSRC; i++) begin
      if (ius[i]) return -1;
      if (ip[i]) return i;
    end
    return -1;
  endfunction

  function automatic int lowest(input logic [NSRC-1:0] v);
    for (int i = 0; i < NSRC; i++) if (v[i]) return i;
    return -1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_ack = 1; m_rd = 1; m_wr = 1; m_done = 0; m_served = 0;
      m_ip = '0; m_ius = '0; m_vec = '0;
    end else begin
      logic frz, tk, rdf, wrf, hit, eoi;
      int s, l;
      frz = (ptr == 2) || (ptr == 3);
      tk  = m_phase && !frz;
      rdf = m_rd && !rd_n;
      wrf = m_wr && !wr_n;
      s   = pick(m_ip, m_ius);
      hit = rdf && !m_ack && !m_done && iei && (s >= 0);
      eoi = wrf && m_ack && !dc && ch;
      l   = lowest(m_ius);
      if (hit) begin
        m_ius[s] = 1'b1;
        m_vec = vec_of(s);
      end else if (eoi && l >= 0) begin
        m_ius[l] = 1'b0;
      end
      if (m_ack) begin m_done = 0; m_served = 0; end
      else begin m_done = m_done | rdf; if (hit) m_served = 1; end
      if (tk) m_ip = src;
      if (!frz) m_phase = !m_phase;
      m_ack = ack_n; m_rd = rd_n; m_wr = wr_n;
    end
  end

  task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    logic e_oe;
    e_oe = m_served && !m_ack && !rd_n;
    chk(tag, "int_no", {7'd0, int_n}, {7'd0, pick(m_ip, m_ius) < 0});
    chk(tag, "ieo", {7'd0, ieo}, {7'd0, iei && m_ius == 0 && m_ip == 0});
    chk(tag, "data_oe", {7'd0, oe}, {7'd0, e_oe});
    chk(tag, "data", data, e_oe ? m_vec : 8'h00);
  endtask

  task automatic cyc(input string tag, input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
      check_all(tag);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd4711));
    @(posedge clk); #1;
    // R1 reset values
    chk("R1", "int_no", {7'd0, int_n}, 8'd1);
    chk("R1", "data_oe", {7'd0, oe}, 8'd0);
    chk("R1", "data", data, 8'd0);
    chk("R1", "ieo", {7'd0, ieo}, 8'd1);
    @(posedge clk); #1 rst_n = 1'b1;
    cyc("R1", 2);

    src = 6'b001100;                          // R9 pending copy
    cyc("R9", 3);
    chk("R9", "int_no pending", {7'd0, int_n}, 8'd0);

    rd_n = 0; cyc("R2"); rd_n = 1; cyc("R2"); // read outside acknowledge
    chk("R2", "no drive", {7'd0, oe}, 8'd0);

    ack_n = 0; cyc("R2");
    rd_n = 0; cyc("R4");
    chk("R5", "vector src2", data, vec_of(2));
    chk("R7", "int_no after claim", {7'd0, int_n}, 8'd1);
    rd_n = 1; cyc("R8");
    rd_n = 0; cyc("R8");                      // second read: nothing new
    rd_n = 1; cyc("R8");
    wr_n = 0; dc = 0; ch = 1; cyc("R3");      // ignored inside acknowledge
    wr_n = 1; cyc("R3");
    ack_n = 1; dc = 1; ch = 0; cyc("R3", 2);
    chk("R6", "src3 masked by src2", {7'd0, int_n}, 8'd1);

    wr_n = 0; dc = 0; ch = 1; cyc("R12");
    wr_n = 1; dc = 1; ch = 0; cyc("R12");
    chk("R12", "int_no after eoi", {7'd0, int_n}, 8'd0);

    iei = 0; cyc("R11");
    chk("R11", "ieo blocked", {7'd0, ieo}, 8'd0);
    src = '0; cyc("R11", 3);
    iei = 1; cyc("R11");
    chk("R11", "ieo pass", {7'd0, ieo}, 8'd1);

    ptr = 3; cyc("R10"); src = 6'b000001; cyc("R10", 6);
    chk("R10", "frozen pending", {7'd0, int_n}, 8'd1);
    ptr = 0; cyc("R10", 3);
    chk("R10", "thawed pending", {7'd0, int_n}, 8'd0);

    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 7) == 0) src = NSRC'($urandom);
      if ($urandom_range(0, 5) == 0) ptr = PTR_W'($urandom_range(0, 2) == 0 ? $urandom_range(2, 3) : $urandom_range(0, 7));
      if ($urandom_range(0, 9) == 0) iei = ~iei;
      if ($urandom_range(0, 7) == 0) ack_n = ~ack_n;
      if ($urandom_range(0, 3) == 0) rd_n = ~rd_n;
      if ($urandom_range(0, 4) == 0) wr_n = ~wr_n;
      dc = 1'($urandom); ch = 1'($urandom);
      cyc("R6");
    end
    finish_run();
  end
endmodule